// File: doc/BRIEF.md
# Transmit Word Queue with Programmable Inter-Word Gap

This block sits between a host that writes bytes and a serial transmit shifter. It holds up to sixteen 8-bit words in arrival order and passes them one at a time to the shifter through a valid/load handshake. Between two handed-off words it can hold back the next one for a programmable number of baud ticks, so a slow far-end receiver gets idle time on the line. A gap of zero sends words back to back.

The host sees the current fill level and one transmit interrupt. In queue mode the interrupt reflects a level comparison against a trigger value. In single-buffer mode it reflects an empty-buffer ready flag. A synchronous run bit empties the queue and drops any pending gap. Bit serialisation and baud generation live elsewhere. The shifter reports when it is idle, and a one-cycle baud tick paces the gap.

Top module: `tx_gap_fifo`

## Requirements
- R1: The queue stores up to 16 words of 8 bits and hands them to the shifter in write order. `fill_cnt` reports the stored count from 0 to 16. A write and a handoff in the same cycle leave the count unchanged.
- R2: A write while `fill_cnt` is 16 is dropped. The count stays 16 and the dropped byte is never offered.
- R3: With `gap_len` = 0, the next stored word is offered as soon as the shifter can load it, without waiting for any baud tick.
- R4: With `gap_len` = N > 0, a handoff (a cycle with `sh_valid` and `sh_load` both high) starts a wait. The next word is offered in the cycle after the N-th cycle in which `baud_tick` and `sh_idle` are both high. Ticks seen while `sh_idle` is low do not count.
- R5: `gap_len` is 9 bits wide and accepts values up to 256.
- R6: When `fifo_mode` = 1, `tx_irq` = `lvl_ie` AND (`fill_cnt` <= `trig_lvl`). With `trig_lvl` = 0, the interrupt is high only when the queue is empty.
- R7: When `fifo_mode` = 0, `tx_irq` = `rdy_ie` AND (`fill_cnt` = 0).
- R8: While `fifo_run` is 0, the queue is emptied at each clock and `sh_valid` is 0. Host writes are dropped. Words that were stored and not yet handed off are discarded.
- R9: Clearing `fifo_run` also drops any pending gap. The first word written after `fifo_run` returns to 1 is offered without waiting for baud ticks.
- R10: After `rst_n` is low, the queue is empty, `sh_valid` is 0 and no gap is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 8 | Host write byte |
| fifo_run | input | 1 | 0 empties the queue and holds it empty; 1 runs |
| fifo_mode | input | 1 | Interrupt source: 1 level compare, 0 empty-buffer flag |
| gap_len | input | 9 | Baud ticks inserted between words (0 to 256) |
| trig_lvl | input | 5 | Fill level at or below which the level interrupt is raised |
| lvl_ie | input | 1 | Enable for the level interrupt |
| rdy_ie | input | 1 | Enable for the empty-buffer interrupt |
| sh_idle | input | 1 | Shifter has finished the previous word |
| sh_load | input | 1 | Shifter takes the offered word this cycle |
| baud_tick | input | 1 | One-cycle baud clock pulse |
| sh_valid | output | 1 | A word is offered to the shifter |
| sh_data | output | 8 | Offered word |
| fill_cnt | output | 5 | Number of stored words |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
A model shifter takes every offered word when idle. It stays busy for a fixed number of cycles after each load, and baud ticks arrive every third cycle. Bursts run with gaps of 0, 3 and 256. For each handoff inside a burst, the count of idle ticks since the previous handoff must equal the programmed gap exactly. This separates a gap that counts busy ticks, ends one tick early or late, or wraps at 255 from a correct one. A held shifter fills the queue to 16 so the bench can check the dropped overflow write and both interrupt sources at the boundaries. A run-bit clear in the middle of a gap shows that the abandoned word is never sent and that the next word leaves without delay.

// File: rtl/tgf_pkg.sv
package tgf_pkg;
    typedef enum logic {
        IRQ_BUF = 1'b0,
        IRQ_LVL = 1'b1
    } irq_src_e;
endpackage

// File: rtl/tgf_store.sv
module tgf_store #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else begin
            if (wr) st_d.wp = step(st_q.wp);
            if (rd) st_d.rp = step(st_q.rp);
            case ({wr, rd})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (run && wr) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R1
    AST_READ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rd) |-> (st_q.cnt != '0)); // R1
endmodule

// File: rtl/tgf_gap.sv
module tgf_gap #(
    parameter int GW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          take,
    input  logic          idle,
    input  logic          tick,
    input  logic [GW-1:0] gap_len,
    output logic          open_o
);
    typedef struct packed {
        logic          pend;
        logic [GW-1:0] cnt;
    } gap_t;

    gap_t gp_d, gp_q;

    always_comb begin
        gp_d = gp_q;
        if (!run) begin
            gp_d = '0;
        end else if (take) begin
            gp_d.pend = 1'b1;
            gp_d.cnt  = '0;
        end else if (gp_q.pend && idle && tick && (gp_q.cnt < gap_len)) begin
            gp_d.cnt = gp_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gp_q <= '0;
        else        gp_q <= gp_d;
    end

    assign open_o = !gp_q.pend || (gp_q.cnt >= gap_len);

    AST_GAP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && take) |=> (open_o == (gap_len == '0))); // R4
    AST_GAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !take && !tick) |=> $stable(gp_q.cnt)); // R4
    AST_GAP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> open_o); // R9
endmodule

// File: rtl/tgf_irq.sv
module tgf_irq #(
    parameter int CW = 5
) (
    input  tgf_pkg::irq_src_e src,
    input  logic              lvl_ie,
    input  logic              rdy_ie,
    input  logic [CW-1:0]     count,
    input  logic [CW-1:0]     trig,
    output logic              irq
);
    always_comb begin
        case (src)
            tgf_pkg::IRQ_LVL: irq = lvl_ie && (count <= trig);
            default:          irq = rdy_ie && (count == '0);
        endcase
    end
endmodule

// File: rtl/tx_gap_fifo.sv
module tx_gap_fifo #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    parameter  int GAP_W = 9,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             fifo_run,
    input  logic             fifo_mode,
    input  logic [GAP_W-1:0] gap_len,
    input  logic [CW-1:0]    trig_lvl,
    input  logic             lvl_ie,
    input  logic             rdy_ie,
    input  logic             sh_idle,
    input  logic             sh_load,
    input  logic             baud_tick,
    output logic             sh_valid,
    output logic [DW-1:0]    sh_data,
    output logic [CW-1:0]    fill_cnt,
    output logic             tx_irq
);
    logic full, empty, gap_open, take, wr_ok;
    logic [CW-1:0] cnt;

    assign wr_ok    = wr_en && fifo_run && !full;
    assign sh_valid = fifo_run && !empty && gap_open;
    assign take     = sh_valid && sh_load;
    assign fill_cnt = cnt;

    tgf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (fifo_run),
        .wr    (wr_ok),
        .wdata (wr_data),
        .rd    (take),
        .rdata (sh_data),
        .count (cnt),
        .full  (full),
        .empty (empty)
    );

    tgf_gap #(.GW(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fifo_run),
        .take    (take),
        .idle    (sh_idle),
        .tick    (baud_tick),
        .gap_len (gap_len),
        .open_o  (gap_open)
    );

    tgf_irq #(.CW(CW)) u_irq (
        .src    (tgf_pkg::irq_src_e'(fifo_mode)),
        .lvl_ie (lvl_ie),
        .rdy_ie (rdy_ie),
        .count  (cnt),
        .trig   (trig_lvl),
        .irq    (tx_irq)
    );

    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        sh_valid |-> (fill_cnt != '0)); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_run && wr_en && (fill_cnt == CW'(DEPTH)) && !take) |=> (fill_cnt == CW'(DEPTH))); // R2
    AST_RUN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_run |=> (fill_cnt == '0)); // R8
    AST_EMPTY_LVL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && lvl_ie && (fill_cnt == '0)) |-> tx_irq); // R6
endmodule

// File: tb/test_tx_gap_fifo.sv
module test_tx_gap_fifo;
    localparam int BUSY = 5;
    localparam int TDIV = 3;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = '0;
    logic       fifo_run = 1;
    logic       fifo_mode = 1;
    logic [8:0] gap_len = '0;
    logic [4:0] trig_lvl = '0;
    logic       lvl_ie = 1;
    logic       rdy_ie = 0;
    logic       sh_idle = 1;
    logic       sh_load = 0;
    logic       baud_tick = 0;
    logic       sh_valid;
    logic [7:0] sh_data;
    logic [4:0] fill_cnt;
    logic       tx_irq;

    int  cmp = 0;
    int  bad = 0;
    int  cyc = 0;
    int  busy = 0;
    int  ticks = 0;
    bit  hold = 0;
    bit  first = 1;
    bit  b2b = 0;
    logic [7:0] q[$];

    always #5 clk = ~clk;

    tx_gap_fifo i_tx_gap_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_run(fifo_run), .fifo_mode(fifo_mode), .gap_len(gap_len),
        .trig_lvl(trig_lvl), .lvl_ie(lvl_ie), .rdy_ie(rdy_ie),
        .sh_idle(sh_idle), .sh_load(sh_load), .baud_tick(baud_tick),
        .sh_valid(sh_valid), .sh_data(sh_data), .fill_cnt(fill_cnt),
        .tx_irq(tx_irq)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
        $finish;
    endtask

    task automatic check(input int act, input int exp, input string tag);
        cmp++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // shifter model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                summary();
            end
            sh_idle   = (busy == 0);
            sh_load   = sh_idle && !hold;
            baud_tick = (cyc % TDIV == 0);
            if (rst_n && sh_valid && sh_load) begin
                if (q.size() == 0) begin
                    check(sh_data, -1, "R8 unexpected word");
                end else begin
                    check(sh_data, q.pop_front(), "R1 order");
                end
                if (!first) begin
                    if (b2b) check(ticks, gap_len, "R4/R3 gap ticks");
                    else     check(ticks >= gap_len, 1, "R4 gap at least");
                end
                first = 0;
                b2b   = (q.size() > 0);
                ticks = 0;
                busy  = BUSY;
            end else begin
                if (sh_idle && baud_tick) ticks++;
                if (busy > 0) busy--;
            end
        end
    end

    task automatic put(input logic [7:0] d, input bit keep);
        @(negedge clk); #1;
        wr_en = 1; wr_data = d;
        if (keep) q.push_back(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            if (q.size() == 0 && fill_cnt == 0 && busy == 0) break;
        end
        check(q.size(), 0, "R1 drained");
    endtask

    task automatic set_hold(input bit h);
        @(negedge clk); #1;
        hold = h;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        check(fill_cnt, 0, "R10 reset fill");
        check(sh_valid, 0, "R10 reset valid");
        check(tx_irq, 1, "R6 empty irq at trig 0");

        // R3: back-to-back burst
        gap_len = 0;
        for (int i = 0; i < 6; i++) put(8'h10 + 8'(i), 1);
        drain();

        // R4: gap of 3 ticks
        gap_len = 3;
        for (int i = 0; i < 5; i++) put(8'h40 + 8'(i), 1);
        drain();

        // R5: maximum gap
        gap_len = 256;
        for (int i = 0; i < 3; i++) put(8'hA0 + 8'(i), 1);
        drain();

        // R2: fill to 16 with the shifter held, then overflow
        gap_len = 0;
        set_hold(1);
        for (int i = 0; i < 16; i++) put(8'(i * 7 + 1), 1);
        check(fill_cnt, 16, "R1 full count");
        put(8'hEE, 0);
        check(fill_cnt, 16, "R2 full write dropped");
        trig_lvl = 16; #1;
        check(tx_irq, 1, "R6 fill equals trig");
        trig_lvl = 15; #1;
        check(tx_irq, 0, "R6 fill above trig");
        fifo_mode = 0; rdy_ie = 1; #1;
        check(tx_irq, 0, "R7 buffer not empty");
        set_hold(0);
        drain();
        check(tx_irq, 1, "R7 buffer empty");
        rdy_ie = 0; #1;
        check(tx_irq, 0, "R7 enable low");
        fifo_mode = 1; trig_lvl = 0;

        // R8 and R9: abandon words and the pending gap
        gap_len = 10;
        put(8'h55, 1);
        put(8'h66, 1);
        put(8'h77, 1);
        set_hold(1);
        @(negedge clk); #1;
        fifo_run = 0;
        q.delete();
        first = 1;
        @(negedge clk); #1;
        check(fill_cnt, 0, "R8 run low empties");
        check(sh_valid, 0, "R8 nothing offered");
        put(8'h99, 0);
        check(fill_cnt, 0, "R8 write while stopped dropped");
        fifo_run = 1;
        put(8'hC3, 1);
        check(sh_valid, 1, "R9 no gap after restart");
        check(sh_data, 8'hC3, "R9 restart word");
        set_hold(0);
        drain();
        check(fill_cnt, 0, "R8 abandoned words never sent");

        summary();
    end
endmodule